// File: doc/BRIEF.md
# APB FIFO peripheral with a defined reset contract

This block is a small APB slave with four registers: a configuration word, an interrupt-mask field, a write-one-to-clear status field, and a data port that feeds a 16-entry FIFO. Software enables the FIFO through configuration bit 0. It pushes entries by writing the data port and pops them by reading it. Three status events can raise a level interrupt: the FIFO filling up, a push while full, and a pop while empty. Each event reaches the interrupt only if its mask bit is set.

Every item that software or the bus can observe comes out of reset at a value that is safe at boot. The raw active-low reset clears all flops at once, with no clock needed. Its release reaches the logic only after two rising edges of the clock. The bus FSM starts in idle and drives ready, error and read data low. The FIFO storage array is not reset. Its pointers and count are reset, so the FIFO reads as empty. A reset that cuts into a transfer discards it.

Top module: `apb_fifo_periph`

## Requirements
- R1: Driving `rst_ni` low clears all state at once, with no clock edge. After `rst_ni` rises at a falling clock edge, the internal logic stays in reset through the next two rising edges. A transfer whose setup phase starts on the following falling edge therefore sees `pready_o` two cycles after `penable_i`, instead of one.
- R2: The configuration register at offset 0x0 resets to 0 and reads back any 32-bit value written to it.
- R3: The interrupt mask at offset 0x4 resets to 0 and holds 3 bits. Bit 0 masks the full event, bit 1 the overflow event and bit 2 the underflow event. Bits 31:3 read as 0.
- R4: The status field at offset 0x8 resets to 0 and has 3 bits: bit 0 full, bit 1 overflow, bit 2 underflow. A write clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: While the internal reset is active, `pready_o`, `pslverr_o`, `prdata_o` and `irq_o` are 0. Outside the cycle in which `pready_o` is high, `prdata_o` is 0.
- R6: A transfer takes one setup cycle, then an access phase. `pready_o` rises on the first clock edge with `penable_i` high and stays high for exactly one cycle. Register and FIFO writes take effect on the edge that ends that cycle.
- R7: A write to offset 0xC pushes `pwdata_i` into the FIFO only while configuration bit 0 is 1. Otherwise the write has no effect. A read of 0xC returns and removes the oldest entry, in first-in first-out order.
- R8: Out of reset the FIFO is empty. A read of 0xC while the FIFO is empty returns 0 and sets status bit 2.
- R9: Status bit 0 sets when a push stores the sixteenth entry. A push while the FIFO is full is discarded and sets status bit 1.
- R10: `irq_o` is high exactly when some status bit is 1 and its mask bit is also 1.
- R11: An access to any address other than 0x0, 0x4, 0x8 or 0xC completes with `pslverr_o` high and `prdata_o` 0. It changes no register and does not touch the FIFO.
- R12: If reset is asserted while a transfer's ready cycle is in progress, that transfer commits nothing. After release, every register reads its reset value and the FIFO reads as empty.
- R13: The first access after reset release returns the reset value of the register read, with `pslverr_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Raw active-low reset, asynchronous |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access-phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W (12) | Byte address |
| pwdata_i | input | DATA_W (32) | Write data |
| pready_o | output | 1 | Transfer completion, one cycle |
| prdata_o | output | DATA_W (32) | Read data, 0 when not ready |
| pslverr_o | output | 1 | Error on an unmapped address |
| irq_o | output | 1 | Level interrupt: status AND mask |

## Verification
Several access patterns are used. The first access right after release tells a two-stage release apart from a shorter one by the number of wait cycles. It also shows whether the registers came out of reset with the right values. A fill of sixteen entries followed by a seventeenth push, then a drain of sixteen entries plus one extra pop, checks the first-in first-out order. It also checks the exact point at which each of the three status events fires, and how the mask gates each event onto the interrupt. Writes to the status field with zero bits and with partial patterns tell write-one-to-clear apart from a plain overwrite. Unmapped and misaligned addresses, disabled pushes, and a reset asserted during a ready cycle are each followed by read-backs, which show that nothing was committed.

// File: rtl/apb_fifo_pkg.sv
package apb_fifo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } bus_state_e;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_FIFO = 2'd3
  } reg_sel_e;

  localparam int unsigned NSTAT    = 3;
  localparam int unsigned STAT_FUL = 0;
  localparam int unsigned STAT_OVF = 1;
  localparam int unsigned STAT_UDF = 2;
endpackage

// File: rtl/apb_rst_sync.sv
module apb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

  // R1
  rst_assert_chk: assert property (@(posedge clk_i) !rst_ni |-> !rst_no);
endmodule

// File: rtl/apb_bus_fsm.sv
module apb_bus_fsm
  import apb_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic              pready_o,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pslverr_o,
  output logic              commit_o
);
  bus_state_e state_q;
  logic       access_start;

  assign access_start = (state_q == ST_SETUP) && psel_i && penable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   state_q <= psel_i ? ST_SETUP : ST_IDLE;
        ST_SETUP:  state_q <= !psel_i ? ST_IDLE : (penable_i ? ST_ACCESS : ST_SETUP);
        ST_ACCESS: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pready_o  <= 1'b0;
      pslverr_o <= 1'b0;
      prdata_o  <= '0;
    end else begin
      pready_o  <= access_start;
      pslverr_o <= access_start && err_i;
      prdata_o  <= (access_start && !err_i) ? rdata_i : '0;
    end
  end

  // the ready cycle commits only while the master still holds the access phase
  assign commit_o = pready_o && psel_i && penable_i;

  // R6
  pready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o |=> !pready_o);
  // R6
  pready_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o |-> (state_q == ST_ACCESS));
  // R5
  idle_data_chk: assert property (@(posedge clk_i)
    !pready_o |-> (prdata_o == '0) && !pslverr_o);
endmodule

// File: rtl/apb_fifo_store.sv
module apb_fifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          head_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign count_o = count_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem[rd_ptr_q];

  // storage deliberately without reset
  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R9
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o && $stable(wr_ptr_q));
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> $stable(rd_ptr_q) && empty_o);
endmodule

// File: rtl/apb_fifo_periph.sv
module apb_fifo_periph
  import apb_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic              pready_o,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pslverr_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);

  logic              rst_n;
  logic              commit;
  logic              addr_ok;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rdata;
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] cfg_q;
  logic [NSTAT-1:0]  mask_q, stat_q, stat_set, stat_clr;
  logic              push, pop;
  logic [DATA_W-1:0] fifo_head;
  logic              fifo_empty, fifo_full;
  logic [CNT_W-1:0]  fifo_count;

  apb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign addr_ok = (paddr_i[1:0] == 2'b00) && (paddr_i[ADDR_W-1:4] == '0);
  assign sel     = reg_sel_e'(paddr_i[3:2]);

  always_comb begin
    case (sel)
      SEL_CFG:  rdata = cfg_q;
      SEL_MASK: rdata = {{(DATA_W-NSTAT){1'b0}}, mask_q};
      SEL_STAT: rdata = {{(DATA_W-NSTAT){1'b0}}, stat_q};
      default:  rdata = fifo_head;
    endcase
  end

  apb_bus_fsm #(.DATA_W(DATA_W)) u_bus_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .rdata_i   (rdata),
    .err_i     (!addr_ok),
    .pready_o  (pready_o),
    .prdata_o  (prdata_o),
    .pslverr_o (pslverr_o),
    .commit_o  (commit)
  );

  assign wr_en = commit && pwrite_i && addr_ok;
  assign rd_en = commit && !pwrite_i && addr_ok;
  assign push  = wr_en && (sel == SEL_FIFO) && cfg_q[0];
  assign pop   = rd_en && (sel == SEL_FIFO);

  apb_fifo_store #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (pwdata_i),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_count)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[STAT_FUL] = push && !fifo_full && (fifo_count == CNT_W'(FIFO_DEPTH-1));
    stat_set[STAT_OVF] = push && fifo_full;
    stat_set[STAT_UDF] = pop && fifo_empty;
    stat_clr           = (wr_en && (sel == SEL_STAT)) ? pwdata_i[NSTAT-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en && (sel == SEL_CFG))  cfg_q  <= pwdata_i;
      if (wr_en && (sel == SEL_MASK)) mask_q <= pwdata_i[NSTAT-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  // R11
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (commit && !addr_ok) |=> $stable(cfg_q) && $stable(mask_q) && $stable(stat_q)
                              && $stable(fifo_count));
  // R7
  push_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (commit && pwrite_i && addr_ok && (sel == SEL_FIFO) && !cfg_q[0]) |=> $stable(fifo_count));
  // R4
  w1c_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en && (sel == SEL_STAT) && (pwdata_i[NSTAT-1:0] == '0)) |=> $stable(stat_q));
  // R5
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_n |-> !irq_o && !pready_o && !pslverr_o);
endmodule

// File: tb/apb_fifo_periph_bench.sv
`timescale 1ns/1ps
module apb_fifo_periph_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        psel_i, penable_i, pwrite_i;
  logic [11:0] paddr_i;
  logic [31:0] pwdata_i;
  logic        pready_o, pslverr_o, irq_o;
  logic [31:0] prdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] exp_data_q [$];
  bit          exp_err_q  [$];
  bit          exp_chk_q  [$];
  string       exp_tag_q  [$];

  localparam logic [11:0] A_CFG = 12'h000, A_MSK = 12'h004, A_STA = 12'h008, A_FIF = 12'h00C;

  always #2.5 clk_i = ~clk_i;

  apb_fifo_periph u_apb_fifo_periph (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .pready_o  (pready_o),
    .prdata_o  (prdata_o),
    .pslverr_o (pslverr_o),
    .irq_o     (irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each completed transfer with the scoreboard
  always @(negedge clk_i) begin
    if (pready_o) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R6 unexpected ready", 32'd1, 32'd0);
      end else begin
        logic [31:0] ed;
        bit ee, ec;
        string tg;
        ed = exp_data_q.pop_front();
        ee = exp_err_q.pop_front();
        ec = exp_chk_q.pop_front();
        tg = exp_tag_q.pop_front();
        check(pslverr_o == ee, {tg, " pslverr"}, {31'd0, pslverr_o}, {31'd0, ee});
        if (ec) check(prdata_o == ed, {tg, " prdata"}, prdata_o, ed);
      end
    end
  end

  task automatic xfer(input bit wr, input logic [11:0] addr, input logic [31:0] wd,
                      input logic [31:0] ed, input bit ee, input int ew,
                      input string tag, input bit abort);
    int waits;
    exp_data_q.push_back(ed);
    exp_err_q.push_back(ee);
    exp_chk_q.push_back(!wr);
    exp_tag_q.push_back(tag);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = wr; paddr_i = addr; pwdata_i = wd;
    @(negedge clk_i);
    penable_i = 1'b1;
    waits = 0;
    do begin
      @(negedge clk_i);
      waits++;
    end while (!pready_o && waits < 20);
    check(waits == ew, {tag, " ready latency"}, waits, ew);
    if (abort) begin
      #1 rst_ni = 1'b0;
      #0.5;
      check(!pready_o && !pslverr_o && prdata_o == 32'd0 && !irq_o,
            "R12 outputs safe at reset entry", {pready_o, pslverr_o, irq_o}, 32'd0);
      psel_i = 1'b0; penable_i = 1'b0;
      return;
    end
    @(negedge clk_i);
    check(!pready_o, "R6 ready one cycle", {31'd0, pready_o}, 32'd0);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 32'd0, 1'b0, 1, tag, 1'b0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, 32'd0, e, 1'b0, 1, tag, 1'b0);
  endtask

  task automatic release_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0; psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
    paddr_i = '0; pwdata_i = '0;
    repeat (3) @(negedge clk_i);
    // R5 outputs during reset
    check(!pready_o && !pslverr_o && prdata_o == 32'd0 && !irq_o,
          "R5 outputs low in reset", prdata_o, 32'd0);
    release_reset();
    // R1 two-stage release; R13 first access returns reset value
    xfer(1'b0, A_CFG, 32'd0, 32'd0, 1'b0, 2, "R1 R13 first cfg read", 1'b0);
    rd(A_MSK, 32'd0, "R3 mask reset");
    rd(A_STA, 32'd0, "R4 status reset");
    rd(A_FIF, 32'd0, "R8 pop empty returns zero");
    rd(A_STA, 32'd4, "R8 underflow flag");
    wr(A_STA, 32'd4, "R4 clear underflow");
    rd(A_STA, 32'd0, "R4 cleared");

    wr(A_CFG, 32'hDEAD_BEE1, "R2 cfg write");
    rd(A_CFG, 32'hDEAD_BEE1, "R2 cfg readback");
    wr(A_MSK, 32'hFFFF_FFFF, "R3 mask write");
    rd(A_MSK, 32'd7, "R3 mask width");
    check(!irq_o, "R10 irq low with no status", {31'd0, irq_o}, 32'd0);
    wr(A_MSK, 32'd0, "R3 mask clear");

    for (int i = 0; i < 16; i++) wr(A_FIF, 32'h100 + i, "R7 push");
    rd(A_STA, 32'd1, "R9 full flag");
    check(!irq_o, "R10 irq masked", {31'd0, irq_o}, 32'd0);
    wr(A_FIF, 32'hBAD, "R9 push while full");
    rd(A_STA, 32'd3, "R9 overflow flag");
    wr(A_MSK, 32'd2, "R10 unmask overflow");
    check(irq_o, "R10 irq on overflow", {31'd0, irq_o}, 32'd1);
    wr(A_MSK, 32'd4, "R10 mask only underflow");
    check(!irq_o, "R10 irq off", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < 16; i++) rd(A_FIF, 32'h100 + i, "R7 pop order");
    rd(A_FIF, 32'd0, "R8 pop past end");
    rd(A_STA, 32'd7, "R8 all flags");
    check(irq_o, "R10 irq on underflow", {31'd0, irq_o}, 32'd1);
    wr(A_STA, 32'd0, "R4 write zero");
    rd(A_STA, 32'd7, "R4 zero keeps flags");
    wr(A_STA, 32'd2, "R4 partial clear");
    rd(A_STA, 32'd5, "R4 partial result");
    wr(A_STA, 32'd5, "R4 clear rest");
    check(!irq_o, "R10 irq after clear", {31'd0, irq_o}, 32'd0);
    rd(A_STA, 32'd0, "R4 empty status");

    wr(A_CFG, 32'd0, "R7 disable");
    wr(A_FIF, 32'h55, "R7 push while disabled");
    rd(A_FIF, 32'd0, "R7 disabled push ignored");
    rd(A_STA, 32'd4, "R7 fifo still empty");
    wr(A_STA, 32'd4, "R4 clear");

    xfer(1'b1, 12'h010, 32'h1234, 32'd0, 1'b1, 1, "R11 write unmapped", 1'b0);
    xfer(1'b0, 12'h010, 32'd0, 32'd0, 1'b1, 1, "R11 read unmapped", 1'b0);
    xfer(1'b1, 12'h002, 32'hFFFF, 32'd0, 1'b1, 1, "R11 misaligned", 1'b0);
    rd(A_CFG, 32'd0, "R11 cfg untouched");
    rd(A_STA, 32'd0, "R11 status untouched");

    wr(A_CFG, 32'd1, "R12 enable");
    wr(A_FIF, 32'h77, "R12 push");
    wr(A_FIF, 32'h78, "R12 push");
    wr(A_MSK, 32'd3, "R12 mask");
    xfer(1'b1, A_CFG, 32'hCAFE, 32'd0, 1'b0, 1, "R12 aborted write", 1'b1);
    release_reset();
    xfer(1'b0, A_CFG, 32'd0, 32'd0, 1'b0, 2, "R12 R13 cfg after abort", 1'b0);
    rd(A_MSK, 32'd0, "R12 mask after abort");
    rd(A_STA, 32'd0, "R12 status after abort");
    rd(A_FIF, 32'd0, "R12 fifo empty after abort");

    repeat (2) @(negedge clk_i);
    check(exp_data_q.size() == 0, "R6 every transfer completed", exp_data_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule